// File: doc/BRIEF.md
# Protected Region Entry/Exit Guard

This block watches the processor's instruction fetch stream and allows control to enter a protected code region at one programmed address only, and to leave it only straight after one of two programmed exit instructions. A bootstrap loader writes the region's lower and upper bounds, its entry address and its two exit addresses through a dedicated load port. The loader does this together with a one-cycle init pulse, once it has verified the image. The processor has no path to these registers.

The guard has three states. In the unarmed state the region cannot be used. In the armed state the region is installed but idle. In the running state protected code is executing. Two flags report the state. Any illegal move into or out of the region raises a one-cycle violation pulse, which the system routes to a non-maskable interrupt. A violation also drops the guard back to the unarmed state, which clears both flags. All outputs are registered.

Top module: `secure_gate`

## Requirements
- R1: After reset, `initFlag`, `secureFlag` and `violation` are all low.
- R2: In the unarmed state, an `ldInit` pulse loads all five address registers from the load port and sets `initFlag` high, with `secureFlag` still low.
- R3: In the armed state, a valid fetch at exactly the entry address moves the guard to running, which sets `secureFlag` high.
- R4: In the armed state, a valid fetch inside the region at any address other than the entry address raises `violation` and clears `initFlag` and `secureFlag`.
- R5: In the armed state, valid fetches outside the region change no output.
- R6: The region is inclusive of both bounds. The low and high addresses count as inside. The addresses one below low and one above high count as outside.
- R7: In the running state, a valid fetch outside the region whose previous valid fetch was the interrupt-exit address returns the guard to armed. `secureFlag` goes low, `initFlag` stays high, and there is no violation.
- R8: The same legal exit as R7 applies when the previous valid fetch was the final-exit address.
- R9: In the running state, a valid fetch outside the region that does not immediately follow an exit-address fetch raises `violation` and clears both flags. This includes the case where an exit-address fetch was followed by another in-region fetch.
- R10: After a violation the guard is unarmed. A fetch at the old entry address is itself a violation, and only a new `ldInit` re-arms the guard.
- R11: An `ldInit` pulse in the armed or running state is ignored. The state and all address registers are unchanged.
- R12: Fetch addresses presented with `fetchValid` low have no effect.
- R13: `violation` is high for exactly one cycle per offending fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldInit | input | 1 | Bootstrap init pulse; loads the address registers |
| ldEntry | input | ADDR_W | Entry address to load |
| ldIrqExit | input | ADDR_W | Interrupt-exit instruction address to load |
| ldFinalExit | input | ADDR_W | Final-exit instruction address to load |
| ldLow | input | ADDR_W | Lower region bound to load (inclusive) |
| ldHigh | input | ADDR_W | Upper region bound to load (inclusive) |
| fetchValid | input | 1 | Instruction fetch strobe |
| fetchAddr | input | ADDR_W | Physical instruction fetch address |
| initFlag | output | 1 | Region installed (armed or running) |
| secureFlag | output | 1 | Protected code is running |
| violation | output | 1 | One-cycle illegal-transition pulse |

## Verification
Every result is registered once. A fetch or init pulse presented before a rising edge shows on `initFlag`, `secureFlag` and `violation` right after that edge, and `violation` falls after the next edge unless another offending fetch arrives. The bench drives each stimulus on a falling edge and samples on the following falling edge, which places every check exactly one edge after its cause. For the "no effect" cases (R5, R11, R12), the bench observes the flags after the stimulus and then confirms through a later fetch that the retained addresses still behave as before.

// File: rtl/sgate_pkg.sv
package sgate_pkg;

  typedef enum logic [1:0] {
    ST_UNARMED = 2'd0,
    ST_ARMED   = 2'd1,
    ST_RUNNING = 2'd2
  } gateState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic trackFetch;
    logic clearTrack;
  } ctrlStrobe_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic inRange;
    logic atEntry;
    logic exitArmed;
  } addrHits_t;

endpackage

// File: rtl/sgate_datapath.sv
module sgate_datapath
  import sgate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] ldEntry,
  input  logic [ADDR_W-1:0] ldIrqExit,
  input  logic [ADDR_W-1:0] ldFinalExit,
  input  logic [ADDR_W-1:0] ldLow,
  input  logic [ADDR_W-1:0] ldHigh,
  input  logic [ADDR_W-1:0] fetchAddr,
  output addrHits_t         hits
);

  localparam int NUM_EXITS = 2;

  logic [ADDR_W-1:0] entryAddr;
  logic [ADDR_W-1:0] lowAddr;
  logic [ADDR_W-1:0] highAddr;
  logic [ADDR_W-1:0] exitAddr [NUM_EXITS];
  logic [ADDR_W-1:0] exitLoad [NUM_EXITS];
  logic [NUM_EXITS-1:0] exitMatch;
  logic exitArmedQ;

  assign exitLoad[0] = ldIrqExit;
  assign exitLoad[1] = ldFinalExit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryAddr <= '0;
      lowAddr   <= '0;
      highAddr  <= '0;
    end else if (strobe.loadCfg) begin
      entryAddr <= ldEntry;
      lowAddr   <= ldLow;
      highAddr  <= ldHigh;
    end
  end

  // one register and one comparator per exit point
  for (genvar gi = 0; gi < NUM_EXITS; gi++) begin : g_exit
    always_ff @(posedge clk) begin
      if (!rstN) exitAddr[gi] <= '0;
      else if (strobe.loadCfg) exitAddr[gi] <= exitLoad[gi];
    end
    assign exitMatch[gi] = (fetchAddr == exitAddr[gi]);
  end

  // remembers whether the latest in-region fetch was an exit instruction
  always_ff @(posedge clk) begin
    if (!rstN) exitArmedQ <= 1'b0;
    else if (strobe.clearTrack) exitArmedQ <= 1'b0;
    else if (strobe.trackFetch) exitArmedQ <= |exitMatch;
  end

  always_comb begin
    hits.inRange   = (fetchAddr >= lowAddr) && (fetchAddr <= highAddr);
    hits.atEntry   = (fetchAddr == entryAddr);
    hits.exitArmed = exitArmedQ;
  end

endmodule

// File: rtl/sgate_ctrl.sv
module sgate_ctrl
  import sgate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ldInit,
  input  logic        fetchValid,
  input  addrHits_t   hits,
  output ctrlStrobe_t strobe,
  output logic        initFlag,
  output logic        secureFlag,
  output logic        violation
);

  gateState_t state, stateNext;
  logic violNext;
  logic violQ;

  always_comb begin
    stateNext = state;
    violNext  = 1'b0;
    strobe    = '0;
    unique case (state)
      ST_UNARMED: begin
        if (ldInit) begin
          strobe.loadCfg    = 1'b1;
          strobe.clearTrack = 1'b1;
          stateNext         = ST_ARMED;
        end else if (fetchValid && hits.inRange) begin
          violNext = 1'b1;
        end
      end
      ST_ARMED: begin
        if (fetchValid && hits.inRange) begin
          if (hits.atEntry) begin
            strobe.clearTrack = 1'b1;
            stateNext         = ST_RUNNING;
          end else begin
            violNext = 1'b1;
          end
        end
      end
      ST_RUNNING: begin
        if (fetchValid) begin
          if (hits.inRange) begin
            strobe.trackFetch = 1'b1;
          end else if (hits.exitArmed) begin
            strobe.clearTrack = 1'b1;
            stateNext         = ST_ARMED;
          end else begin
            violNext = 1'b1;
          end
        end
      end
      default: violNext = 1'b1;
    endcase
    if (violNext) begin
      stateNext         = ST_UNARMED;
      strobe.clearTrack = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_UNARMED;
      violQ <= 1'b0;
    end else begin
      state <= stateNext;
      violQ <= violNext;
    end
  end

  assign initFlag   = (state != ST_UNARMED);
  assign secureFlag = (state == ST_RUNNING);
  assign violation  = violQ;

endmodule

// File: rtl/secure_gate.sv
module secure_gate
  import sgate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldInit,
  input  logic [ADDR_W-1:0] ldEntry,
  input  logic [ADDR_W-1:0] ldIrqExit,
  input  logic [ADDR_W-1:0] ldFinalExit,
  input  logic [ADDR_W-1:0] ldLow,
  input  logic [ADDR_W-1:0] ldHigh,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              initFlag,
  output logic              secureFlag,
  output logic              violation
);

  ctrlStrobe_t strobe;
  addrHits_t   hits;

  sgate_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .ldEntry    (ldEntry),
    .ldIrqExit  (ldIrqExit),
    .ldFinalExit(ldFinalExit),
    .ldLow      (ldLow),
    .ldHigh     (ldHigh),
    .fetchAddr  (fetchAddr),
    .hits       (hits)
  );

  sgate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ldInit    (ldInit),
    .fetchValid(fetchValid),
    .hits      (hits),
    .strobe    (strobe),
    .initFlag  (initFlag),
    .secureFlag(secureFlag),
    .violation (violation)
  );

endmodule

// File: rtl/sgate_checker.sv
module sgate_checker (
  input logic clk,
  input logic rstN,
  input logic ldInit,
  input logic fetchValid,
  input logic initFlag,
  input logic secureFlag,
  input logic violation
);

  // R3: running implies installed
  assert_running_implies_armed_R3: assert property (@(posedge clk) disable iff (!rstN)
    secureFlag |-> initFlag);

  // R4 / R9: a violation leaves both flags cleared
  assert_violation_clears_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> (!initFlag && !secureFlag));

  // R2: arming only follows an init pulse
  assert_arm_needs_init_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initFlag) |-> $past(ldInit));

  // R3: entry happens only from armed on a valid fetch
  assert_entry_from_armed_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(secureFlag) |-> ($past(initFlag) && $past(fetchValid)));

  // R12: no violation without a valid fetch
  assert_violation_needs_fetch_R12: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> $past(fetchValid));

  // R7: leaving running needs a valid fetch
  assert_exit_needs_fetch_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(secureFlag) |-> $past(fetchValid));

endmodule

bind secure_gate sgate_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ldInit    (ldInit),
  .fetchValid(fetchValid),
  .initFlag  (initFlag),
  .secureFlag(secureFlag),
  .violation (violation)
);

// File: tb/secure_gate_bench.sv
`timescale 1ns/1ps
module secure_gate_bench;

  localparam int AW = 32;
  localparam logic [AW-1:0] LOW   = 32'h0000_1000;
  localparam logic [AW-1:0] HIGH  = 32'h0000_10FF;
  localparam logic [AW-1:0] ENTRY = 32'h0000_1010;
  localparam logic [AW-1:0] IRQX  = 32'h0000_1080;
  localparam logic [AW-1:0] FINX  = 32'h0000_10F0;

  logic clk = 1'b0;
  logic rstN;
  logic ldInit;
  logic [AW-1:0] ldEntry, ldIrqExit, ldFinalExit, ldLow, ldHigh;
  logic fetchValid;
  logic [AW-1:0] fetchAddr;
  logic initFlag, secureFlag, violation;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  secure_gate #(.ADDR_W(AW)) u_secure_gate (
    .clk(clk), .rstN(rstN), .ldInit(ldInit),
    .ldEntry(ldEntry), .ldIrqExit(ldIrqExit), .ldFinalExit(ldFinalExit),
    .ldLow(ldLow), .ldHigh(ldHigh),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .initFlag(initFlag), .secureFlag(secureFlag), .violation(violation)
  );

  task automatic check3(input string req, input logic expInit, input logic expSec,
                        input logic expViol);
    nChecks++;
    if ({initFlag, secureFlag, violation} !== {expInit, expSec, expViol}) begin
      nFails++;
      $display("FAIL %s: init/secure/viol actual %b%b%b expected %b%b%b", req,
               initFlag, secureFlag, violation, expInit, expSec, expViol);
    end
  endtask

  task automatic loadCfg(input logic [AW-1:0] e);
    ldEntry = e; ldIrqExit = IRQX; ldFinalExit = FINX; ldLow = LOW; ldHigh = HIGH;
    ldInit = 1'b1;
    @(negedge clk);
    ldInit = 1'b0;
  endtask

  task automatic fetch(input logic [AW-1:0] a);
    fetchValid = 1'b1; fetchAddr = a;
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check3("R1 reset", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_arm();
    loadCfg(ENTRY);
    check3("R2 init arms", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_outside();
    fetch(32'h0000_2000); check3("R5 far outside", 1'b1, 1'b0, 1'b0);
    fetch(LOW - 1);       check3("R6 low-1 outside", 1'b1, 1'b0, 1'b0);
    fetch(HIGH + 1);      check3("R6 high+1 outside", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_badEntry();
    fetch(HIGH);
    check3("R4 R6 in-range non-entry at high bound", 1'b0, 1'b0, 1'b1);
    idle();
    check3("R13 pulse one cycle", 1'b0, 1'b0, 1'b0);
    fetch(ENTRY);
    check3("R10 entry while unarmed", 1'b0, 1'b0, 1'b1);
    idle();
    loadCfg(ENTRY);
    check3("R10 rearm", 1'b1, 1'b0, 1'b0);
    fetch(LOW);
    check3("R6 low bound is inside", 1'b0, 1'b0, 1'b1);
    idle();
    loadCfg(ENTRY);
  endtask

  task automatic t_noValid();
    fetchValid = 1'b0; fetchAddr = LOW + 4;
    idle();
    check3("R12 invalid fetch ignored", 1'b1, 1'b0, 1'b0);
    fetch(ENTRY);
    check3("R12 then entry still works", 1'b1, 1'b1, 1'b0);
    fetchValid = 1'b0; fetchAddr = 32'h0000_9000;
    idle();
    check3("R12 invalid outside fetch while running", 1'b1, 1'b1, 1'b0);
    fetch(IRQX); fetch(32'h0000_3000);
  endtask

  task automatic t_irqExit();
    fetch(ENTRY);
    check3("R3 legal entry", 1'b1, 1'b1, 1'b0);
    fetch(LOW + 32'h20);
    fetch(IRQX);
    check3("R3 running in region", 1'b1, 1'b1, 1'b0);
    fetch(32'h0000_3000);
    check3("R7 interrupt exit", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_finalExit();
    fetch(ENTRY);
    fetch(FINX);
    fetch(32'h0000_4000);
    check3("R8 final exit", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_escape();
    fetch(ENTRY);
    fetch(LOW + 32'h30);
    fetch(32'h0000_5000);
    check3("R9 escape without exit", 1'b0, 1'b0, 1'b1);
    idle();
    loadCfg(ENTRY);
    fetch(ENTRY);
    fetch(IRQX);
    fetch(IRQX + 4);
    fetch(32'h0000_5000);
    check3("R9 stale exit", 1'b0, 1'b0, 1'b1);
    idle();
    loadCfg(ENTRY);
    fetch(ENTRY);
    fetch(32'h0000_5000);
    check3("R9 leave right after entry", 1'b0, 1'b0, 1'b1);
    idle();
    loadCfg(ENTRY);
  endtask

  task automatic t_reinitIgnored();
    loadCfg(32'h0000_1040);
    check3("R11 init in armed ignored", 1'b1, 1'b0, 1'b0);
    fetch(ENTRY);
    check3("R11 old entry retained", 1'b1, 1'b1, 1'b0);
    loadCfg(32'h0000_1040);
    check3("R11 init in running ignored", 1'b1, 1'b1, 1'b0);
    fetch(FINX);
    fetch(32'h0000_6000);
    check3("R11 exit after ignored init", 1'b1, 1'b0, 1'b0);
    fetch(32'h0000_1040);
    check3("R11 new entry not loaded", 1'b0, 1'b0, 1'b1);
    idle();
  endtask

  initial begin
    rstN = 1'b0; ldInit = 1'b0; fetchValid = 1'b0; fetchAddr = '0;
    ldEntry = '0; ldIrqExit = '0; ldFinalExit = '0; ldLow = '0; ldHigh = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_arm();
    t_outside();
    t_badEntry();
    t_noValid();
    t_irqExit();
    t_finalExit();
    t_escape();
    t_reinitIgnored();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule